// File: doc/BRIEF.md
# Power stage fault supervisor

This block watches the protection flags of a power stage made of four half-bridges and decides, cycle by cycle, which bridges must float their outputs. It takes one overcurrent shutdown request per bridge, one overtemperature warning, one overtemperature shutdown and one gate-supply undervoltage flag. Every one of these flags, and the external clear request, first passes through a two-flop synchroniser. From the synchronised flags the block drives one high-impedance enable per bridge and two active-low status outputs, a fault line and a warning line.

Undervoltage is a self-clearing condition. Floating lasts only while the flag is present. Overcurrent and overtemperature shutdowns latch. A latch starts a hold-off counter when it is set, and an external clear request removes it only once that counter has run out. The default hold-off is one second at a 125 MHz clock. A clear request that arrives early is dropped, not remembered. Each bridge has its own overcurrent latch, so one shorted bridge does not take the others down.

Top module: `pstage_fault_sup`

## Requirements
- R1: After power-on reset with all inputs low, every bit of `hiz_en` is 0 and both `fault_n` and `warn_n` are 1.
- R2: `warn_n` is 0 exactly while the synchronised `ot_warn` is 1. Every input reaches the logic two clock edges after it is driven.
- R3: The pair {`fault_n`,`warn_n`} reads 00 for a shutdown plus a warning, 01 for a shutdown alone, 10 for a warning alone and 11 for normal operation.
- R4: When the synchronised `oc_req[i]` is 1, `hiz_en[i]` (bit i belongs to bridge i, bit 0 = bridge A) is 1 in that same cycle, with no extra register.
- R5: An overtemperature shutdown sets all `hiz_en` bits while the synchronised flag is present and while its latch is held.
- R6: Undervoltage sets all `hiz_en` bits and drives `fault_n` low only while the synchronised flag is present. When the flag drops and nothing else is pending, outputs re-enable and `fault_n` returns to 1 in the same cycle.
- R7: An overcurrent or overtemperature shutdown stays in force after its input returns to 0.
- R8: A clear request seen before HOLD_CYCLES clock edges have passed since a latch was set leaves that latch set. It is also not stored for later.
- R9: A synchronised clear request that is present after the hold-off has expired clears that latch on the next edge.
- R10: `fault_n` is 0 while any latch is set or any shutdown flag is present.
- R11: Each overcurrent latch has its own hold-off. A clear request frees only the bridges whose hold-off has expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, clears synchronisers and latches |
| oc_req | input | NUM_BRIDGES | Overcurrent shutdown request per bridge |
| ot_warn | input | 1 | Overtemperature warning flag |
| ot_shut | input | 1 | Overtemperature shutdown flag |
| uv_flag | input | 1 | Gate-supply undervoltage flag |
| clr_req | input | 1 | External request to clear latched shutdowns |
| hiz_en | output | NUM_BRIDGES | Per-bridge high-impedance enable |
| fault_n | output | 1 | Active-low shutdown status |
| warn_n | output | 1 | Active-low overtemperature warning status |

## Verification
Suppose a latch clears too early, or its hold-off counter runs short. Then `hiz_en` and `fault_n` return to their idle values one edge after a clear request that should have been dropped, so the bench checks the ports right after early clear attempts and again well after them. A latch that never sets shows up at most three edges after the input is driven, because the enable falls as soon as the flag is removed. A wrong bridge mask or a wrong status code shows in the same cycle as the synchronised flag. The random phase compares every cycle against a model built from the requirements.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  // Status pair {fault_n, warn_n}: both active low.
  function automatic logic [1:0] status_pair(input logic shut, input logic warn);
    return {~shut, ~warn};
  endfunction

  // Hold-off counter width for a given cycle count.
  function automatic int unsigned hold_width(input int unsigned cycles);
    return (cycles < 2) ? 1 : $clog2(cycles + 1);
  endfunction

endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pfs_latch.sv
module pfs_latch
  import pfs_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 125_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic clr,
  output logic lat,
  output logic done
);
  localparam int unsigned CW = hold_width(HOLD_CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES);

  logic [CW-1:0] age;

  assign done = lat && (age == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat <= 1'b0;
      age <= '0;
    end else if (lat) begin
      if (age != LIMIT) age <= age + CW'(1);
      else if (clr)     lat <= 1'b0;
    end else if (trig) begin
      lat <= 1'b1;
      age <= '0;
    end
  end
endmodule

// File: rtl/pstage_fault_sup.sv
module pstage_fault_sup
  import pfs_pkg::*;
#(
  parameter int unsigned NUM_BRIDGES = 4,
  parameter int unsigned HOLD_CYCLES = 125_000_000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_BRIDGES-1:0] oc_req,
  input  logic                   ot_warn,
  input  logic                   ot_shut,
  input  logic                   uv_flag,
  input  logic                   clr_req,
  output logic [NUM_BRIDGES-1:0] hiz_en,
  output logic                   fault_n,
  output logic                   warn_n
);
  localparam int unsigned SW = NUM_BRIDGES + 4;

  logic [SW-1:0]          sync_q;
  logic [NUM_BRIDGES-1:0] oc_s, oc_lat, oc_done;
  logic warn_s, ot_s, uv_s, clr_s;
  logic ot_lat, ot_done;
  logic all_float, shut_any;

  pfs_sync #(.W(SW)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({oc_req, ot_warn, ot_shut, uv_flag, clr_req}),
    .q(sync_q)
  );
  assign {oc_s, warn_s, ot_s, uv_s, clr_s} = sync_q;

  for (genvar g = 0; g < NUM_BRIDGES; g++) begin : g_oc
    pfs_latch #(.HOLD_CYCLES(HOLD_CYCLES)) u_oc (
      .clk(clk), .rst_n(rst_n), .trig(oc_s[g]), .clr(clr_s),
      .lat(oc_lat[g]), .done(oc_done[g])
    );
  end

  pfs_latch #(.HOLD_CYCLES(HOLD_CYCLES)) u_ot (
    .clk(clk), .rst_n(rst_n), .trig(ot_s), .clr(clr_s),
    .lat(ot_lat), .done(ot_done)
  );

  assign all_float = ot_s | ot_lat | uv_s;
  assign shut_any  = all_float | (|oc_s) | (|oc_lat);
  assign hiz_en    = oc_s | oc_lat | {NUM_BRIDGES{all_float}};
  assign {fault_n, warn_n} = status_pair(shut_any, warn_s);
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker #(
  parameter int unsigned NUM_BRIDGES = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_BRIDGES-1:0] oc_s,
  input logic [NUM_BRIDGES-1:0] oc_lat,
  input logic [NUM_BRIDGES-1:0] oc_done,
  input logic                   warn_s,
  input logic                   ot_s,
  input logic                   uv_s,
  input logic                   clr_s,
  input logic                   ot_lat,
  input logic                   ot_done,
  input logic [NUM_BRIDGES-1:0] hiz_en,
  input logic                   fault_n,
  input logic                   warn_n
);
  AST_OC_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_s & ~hiz_en) == '0); // R4
  AST_OT_ALL_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_s || ot_lat) |-> (&hiz_en)); // R5
  AST_UV_ALL_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    uv_s |-> ((&hiz_en) && !fault_n)); // R6
  AST_UV_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(uv_s) && !ot_s && !ot_lat && oc_s == '0 && oc_lat == '0)
      |-> (fault_n && hiz_en == '0)); // R6
  AST_WARN_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    warn_n != warn_s); // R2
  AST_FAULT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((|oc_lat) || ot_lat || uv_s) |-> !fault_n); // R10
  AST_OT_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_lat && !ot_done) |=> ot_lat); // R8
  AST_OT_CLEAR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ot_lat) |-> $past(ot_done && clr_s)); // R9
  AST_NO_SPILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!ot_s && !ot_lat && !uv_s) |-> ((hiz_en & ~(oc_s | oc_lat)) == '0)); // R11

  for (genvar g = 0; g < NUM_BRIDGES; g++) begin : g_chk
    AST_OC_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_lat[g] && !oc_done[g]) |=> oc_lat[g]); // R7
    AST_OC_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oc_lat[g]) |-> $past(oc_done[g] && clr_s)); // R11
  end
endmodule

bind pstage_fault_sup pfs_checker #(.NUM_BRIDGES(NUM_BRIDGES)) u_pfs_chk (
  .clk(clk), .rst_n(rst_n), .oc_s(oc_s), .oc_lat(oc_lat), .oc_done(oc_done),
  .warn_s(warn_s), .ot_s(ot_s), .uv_s(uv_s), .clr_s(clr_s),
  .ot_lat(ot_lat), .ot_done(ot_done), .hiz_en(hiz_en),
  .fault_n(fault_n), .warn_n(warn_n)
);

// File: tb/sim_pstage_fault_sup.sv
`timescale 1ns/1ps
module sim_pstage_fault_sup;
  localparam int NB   = 4;
  localparam int HOLD = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB-1:0] oc_req = '0;
  logic ot_warn = 1'b0, ot_shut = 1'b0, uv_flag = 1'b0, clr_req = 1'b0;
  logic [NB-1:0] hiz_en;
  logic fault_n, warn_n;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pstage_fault_sup #(.NUM_BRIDGES(NB), .HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .oc_req(oc_req), .ot_warn(ot_warn),
    .ot_shut(ot_shut), .uv_flag(uv_flag), .clr_req(clr_req),
    .hiz_en(hiz_en), .fault_n(fault_n), .warn_n(warn_n)
  );

  // Requirement-level model: two-edge input delay, latches with age counts.
  logic [NB-1:0] m_oc1, m_oc2, m_lat;
  logic m_w1, m_w2, m_t1, m_t2, m_u1, m_u2, m_c1, m_c2, m_tlat;
  int m_age [NB];
  int m_tage;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_oc1 <= '0; m_oc2 <= '0; m_lat <= '0; m_tlat <= 1'b0; m_tage <= 0;
      {m_w1, m_w2, m_t1, m_t2, m_u1, m_u2, m_c1, m_c2} <= '0;
      for (int i = 0; i < NB; i++) m_age[i] <= 0;
    end else begin
      m_oc1 <= oc_req; m_oc2 <= m_oc1;
      m_w1 <= ot_warn; m_w2 <= m_w1;
      m_t1 <= ot_shut; m_t2 <= m_t1;
      m_u1 <= uv_flag; m_u2 <= m_u1;
      m_c1 <= clr_req; m_c2 <= m_c1;
      for (int i = 0; i < NB; i++) begin
        if (m_lat[i]) begin
          if (m_age[i] < HOLD) m_age[i] <= m_age[i] + 1;
          else if (m_c2) m_lat[i] <= 1'b0;
        end else if (m_oc2[i]) begin
          m_lat[i] <= 1'b1; m_age[i] <= 0;
        end
      end
      if (m_tlat) begin
        if (m_tage < HOLD) m_tage <= m_tage + 1;
        else if (m_c2) m_tlat <= 1'b0;
      end else if (m_t2) begin
        m_tlat <= 1'b1; m_tage <= 0;
      end
    end
  end

  function automatic logic [1:0] bench_code(input logic shut, input logic warn);
    case ({shut, warn})
      2'b11:   return 2'b00;
      2'b10:   return 2'b01;
      2'b01:   return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic [NB-1:0] bench_hiz();
    if (m_t2 || m_tlat || m_u2) return '1;
    return m_oc2 | m_lat;
  endfunction

  function automatic logic bench_shut();
    return m_t2 || m_tlat || m_u2 || (m_oc2 != '0) || (m_lat != '0);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_check();
    check("R4 hiz vs model", 32'(hiz_en), 32'(bench_hiz()));
    check("R3 status vs model", 32'({fault_n, warn_n}), 32'(bench_code(bench_shut(), m_w2)));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h1f2e3d4c));
    tick(3);
    rst_n = 1'b1;
    tick(2);
    check("R1 reset hiz", 32'(hiz_en), 0);
    check("R1 reset status", 32'({fault_n, warn_n}), 32'h3);

    // R4 / R10 / R3: single bridge overcurrent
    oc_req = 4'b0100;
    tick(1);
    check("R2 not yet visible after one edge", 32'(hiz_en), 0);
    tick(1);
    check("R4 only bridge 2 floats", 32'(hiz_en), 32'h4);
    check("R3 shutdown-only code 01", 32'({fault_n, warn_n}), 32'h1);
    oc_req = '0;
    tick(3);
    check("R7 oc latch persists", 32'(hiz_en), 32'h4);
    check("R10 fault low while latched", 32'(fault_n), 0);
    // R8: early clear ignored, not queued
    clr_req = 1'b1; tick(3); clr_req = 1'b0;
    tick(3);
    check("R8 early clear ignored", 32'(hiz_en), 32'h4);
    tick(HOLD + 5);
    check("R8 early clear not queued", 32'(hiz_en), 32'h4);
    clr_req = 1'b1; tick(3);
    check("R9 clear after hold-off hiz", 32'(hiz_en), 0);
    check("R9 clear after hold-off status", 32'({fault_n, warn_n}), 32'h3);
    clr_req = 1'b0;

    // R2 / R3 warning only, then R5 with warning
    ot_warn = 1'b1; tick(2);
    check("R2 warn_n low", 32'(warn_n), 0);
    check("R3 warning-only code 10", 32'({fault_n, warn_n}), 32'h2);
    check("R2 warning floats nothing", 32'(hiz_en), 0);
    ot_shut = 1'b1; tick(2);
    check("R5 all bridges float", 32'(hiz_en), 32'hF);
    check("R3 both code 00", 32'({fault_n, warn_n}), 32'h0);
    ot_shut = 1'b0; tick(4);
    check("R7 ot latch persists", 32'(hiz_en), 32'hF);
    tick(HOLD + 3);
    ot_warn = 1'b0; clr_req = 1'b1; tick(3);
    check("R9 ot cleared", 32'(hiz_en), 0);
    check("R9 ot cleared status", 32'({fault_n, warn_n}), 32'h3);
    clr_req = 1'b0;

    // R6 undervoltage self-clears
    uv_flag = 1'b1; tick(2);
    check("R6 uv floats all", 32'(hiz_en), 32'hF);
    check("R6 uv fault low", 32'(fault_n), 0);
    uv_flag = 1'b0; tick(2);
    check("R6 uv recovered hiz", 32'(hiz_en), 0);
    check("R6 uv recovered fault_n", 32'(fault_n), 1);

    // R11 independent hold-offs
    oc_req = 4'b0001; tick(2); oc_req = '0;
    tick(20);
    oc_req = 4'b1000; tick(2); oc_req = '0;
    tick(24);
    clr_req = 1'b1; tick(3);
    check("R11 only expired bridge freed", 32'(hiz_en), 32'h8);
    tick(20);
    check("R11 second bridge freed later", 32'(hiz_en), 0);
    clr_req = 1'b0;
    tick(3);

    // Random phase against the model
    for (int n = 0; n < 3000; n++) begin
      model_check();
      for (int b = 0; b < NB; b++)
        if ($urandom % 60 == 0) oc_req[b] = ~oc_req[b];
      if ($urandom % 30 == 0) ot_warn = ~ot_warn;
      if ($urandom % 150 == 0) ot_shut = ~ot_shut;
      if ($urandom % 70 == 0) uv_flag = ~uv_flag;
      clr_req = ($urandom % 8 == 0);
      tick(1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule